// File: doc/BRIEF.md
# UART interrupt status controller

This block gathers the condition and event flags of a serial port and turns them into the interrupt view that software sees. It compares the receive and transmit FIFO occupancy counts against their full depth and against two programmable trigger levels, and it presents the result as a live status word. A sticky interrupt status register latches those conditions together with single-cycle event pulses from the receiver and transmitter: overrun, framing error, parity error, receive timeout, modem status change and transmit overrun.

A mask register selects which sticky bits may raise the single level interrupt output. Software never writes the mask directly. One address sets mask bits and another clears them. Sticky bits are cleared by writing ones to them. A simple synchronous write port and a combinational read port give access to the enable, disable, mask, sticky, live and trigger-level addresses. The FIFOs, shifters and bus bridge stay outside; the FIFO counts arrive as plain inputs.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: The live status word is combinational and has the following bits: bit0 is set when the RX count is at or above the RX trigger level; bit1 when the RX count is zero; bit2 when the RX count equals RX_DEPTH; bit3 when the TX count is zero; bit4 when the TX count equals TX_DEPTH; bit13 when the TX count is at or above the TX trigger level. Every other bit reads zero.
- R2: On each clock edge, the sticky register ORs in live bits 4:0 at the same positions. It also ORs in live bit13, but at its own bit10.
- R3: An event pulse sets a sticky bit at the next clock edge. The bit positions are: RX overrun at bit5, framing error at bit6, parity error at bit7, receive timeout at bit8, modem status change at bit9 and TX overrun at bit12.
- R4: A sticky bit stays set until a write to address 3 carries a one in that position. Zeros in the written word leave the corresponding bits unchanged.
- R5: A write-one-to-clear and a set request can reach the same sticky bit in the same cycle. In that case the bit stays set. Other bits cleared in the same write still clear.
- R6: A write to address 0 ORs the data into the mask. A write to address 1 clears the mask bits written as one. A write to address 2 leaves the mask unchanged. Only bits 0 to 10 and bit 12 exist in the mask and sticky registers; all other bits read zero.
- R7: The interrupt output is registered. It equals the OR over the AND of mask and sticky as they stood one clock earlier.
- R8: While reset is held, the mask, the sticky register and the interrupt output are zero, and both trigger levels read 32.
- R9: A write to address 5 sets the RX trigger level and a write to address 6 sets the TX trigger level. Each keeps the low count-width bits of the written data.
- R10: The read port returns the mask at address 2, the sticky register at address 3, the live word at address 4, and the RX and TX trigger levels at addresses 5 and 6. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_count | input | RX_CNT_W | Receive FIFO occupancy |
| tx_count | input | TX_CNT_W | Transmit FIFO occupancy |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem_chg | input | 1 | Modem status change pulse |
| ev_tx_overrun | input | 1 | Transmit overrun pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | REG_W | Register read data, combinational |
| live_status | output | REG_W | Live status word |
| irq_status | output | REG_W | Sticky interrupt status |
| irq_mask | output | REG_W | Interrupt mask |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a collision on one sticky bit: the clearing write and a new set request must land in the same clock. The stimulus creates it by driving the write strobe and an event pulse on the same falling edge. A second collision comes from a level condition that still holds while software clears it. The one-cycle lag of the interrupt output is only visible if the mask changes under a bit that is already set. The bench therefore sets the sticky bit first, then enables its mask bit, and samples the output on each of the two following cycles. The live word is swept over every RX count against several trigger levels, from zero up to the full depth.

// File: rtl/uisc_pkg.sv
package uisc_pkg;

   // live status word positions
   localparam int LV_RX_TRIG  = 0;
   localparam int LV_RX_EMPTY = 1;
   localparam int LV_RX_FULL  = 2;
   localparam int LV_TX_EMPTY = 3;
   localparam int LV_TX_FULL  = 4;
   localparam int LV_TX_TRIG  = 13;

   // sticky register positions (0..4 mirror the live word)
   localparam int IS_RX_OVR  = 5;
   localparam int IS_FRAME   = 6;
   localparam int IS_PARITY  = 7;
   localparam int IS_TIMEOUT = 8;
   localparam int IS_MODEM   = 9;
   localparam int IS_TX_TRIG = 10;
   localparam int IS_TX_OVR  = 12;

   localparam int IS_W = 13;
   localparam logic [IS_W-1:0] IS_IMPL = 13'h17FF;

   typedef enum logic [2:0] {
      A_ENABLE  = 3'd0,
      A_DISABLE = 3'd1,
      A_MASK    = 3'd2,
      A_STICKY  = 3'd3,
      A_LIVE    = 3'd4,
      A_RXTRIG  = 3'd5,
      A_TXTRIG  = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic rx_ovr;
      logic frame;
      logic parity;
      logic timeout;
      logic modem;
      logic tx_ovr;
   } evt_s;

endpackage

// File: rtl/uisc_level_flags.sv
module uisc_level_flags
   import uisc_pkg::*;
#(
   parameter int RX_DEPTH = 64,
   parameter int TX_DEPTH = 64,
   parameter int RX_CNT_W = $clog2(RX_DEPTH + 1),
   parameter int TX_CNT_W = $clog2(TX_DEPTH + 1),
   parameter int REG_W    = 32
) (
   input  logic [RX_CNT_W-1:0] rx_count_i,
   input  logic [TX_CNT_W-1:0] tx_count_i,
   input  logic [RX_CNT_W-1:0] rx_trig_i,
   input  logic [TX_CNT_W-1:0] tx_trig_i,
   output logic [REG_W-1:0]    live_o
);

   localparam logic [RX_CNT_W-1:0] RX_FULL_V = RX_CNT_W'(RX_DEPTH);
   localparam logic [TX_CNT_W-1:0] TX_FULL_V = TX_CNT_W'(TX_DEPTH);

   always_comb begin
      live_o              = '0;
      live_o[LV_RX_TRIG]  = (rx_count_i >= rx_trig_i);
      live_o[LV_RX_EMPTY] = (rx_count_i == '0);
      live_o[LV_RX_FULL]  = (rx_count_i == RX_FULL_V);
      live_o[LV_TX_EMPTY] = (tx_count_i == '0);
      live_o[LV_TX_FULL]  = (tx_count_i == TX_FULL_V);
      live_o[LV_TX_TRIG]  = (tx_count_i >= tx_trig_i);
   end

endmodule

// File: rtl/uisc_bit_bank.sv
module uisc_bit_bank #(
   parameter int            W    = 13,
   parameter logic [W-1:0]  IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] unused_in;

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (IMPL[b]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         bit_q <= 1'b0;
            else if (set_i[b])  bit_q <= 1'b1;
            else if (clr_i[b])  bit_q <= 1'b0;
         end
         assign q_o[b]       = bit_q;
         assign unused_in[b] = 1'b0;
      end else begin : g_tie
         assign q_o[b]       = 1'b0;
         assign unused_in[b] = set_i[b] ^ clr_i[b];
      end
   end

endmodule

// File: rtl/uisc_trig_regs.sv
module uisc_trig_regs #(
   parameter int RX_CNT_W    = 7,
   parameter int TX_CNT_W    = 7,
   parameter int RX_RST_TRIG = 32,
   parameter int TX_RST_TRIG = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_we_i,
   input  logic                tx_we_i,
   input  logic [RX_CNT_W-1:0] rx_wdata_i,
   input  logic [TX_CNT_W-1:0] tx_wdata_i,
   output logic [RX_CNT_W-1:0] rx_trig_o,
   output logic [TX_CNT_W-1:0] tx_trig_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_trig_o <= RX_CNT_W'(RX_RST_TRIG);
         tx_trig_o <= TX_CNT_W'(TX_RST_TRIG);
      end else begin
         if (rx_we_i) rx_trig_o <= rx_wdata_i;
         if (tx_we_i) tx_trig_o <= tx_wdata_i;
      end
   end

endmodule

// File: rtl/uisc_irq_out.sv
module uisc_irq_out #(
   parameter int W        = 13,
   parameter bit SYNC_IRQ = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] sticky_i,
   output logic         irq_o
);

   logic hit;
   assign hit = |(mask_i & sticky_i);

   if (SYNC_IRQ) begin : g_sync
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o      = hit;
   end

endmodule

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
   import uisc_pkg::*;
#(
   parameter int RX_DEPTH    = 64,
   parameter int TX_DEPTH    = 64,
   parameter int RX_CNT_W    = $clog2(RX_DEPTH + 1),
   parameter int TX_CNT_W    = $clog2(TX_DEPTH + 1),
   parameter int RX_RST_TRIG = 32,
   parameter int TX_RST_TRIG = 32,
   parameter int REG_W       = 32,
   parameter int ADDR_W      = 4,
   parameter bit SYNC_IRQ    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RX_CNT_W-1:0] rx_count,
   input  logic [TX_CNT_W-1:0] tx_count,
   input  logic                ev_rx_overrun,
   input  logic                ev_frame_err,
   input  logic                ev_parity_err,
   input  logic                ev_rx_timeout,
   input  logic                ev_modem_chg,
   input  logic                ev_tx_overrun,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [REG_W-1:0]    rd_data,
   output logic [REG_W-1:0]    live_status,
   output logic [REG_W-1:0]    irq_status,
   output logic [REG_W-1:0]    irq_mask,
   output logic                irq
);

   // elaboration-time parameter checks
   if (RX_DEPTH < 1 || TX_DEPTH < 1) begin : g_bad_depth
      $error("uart_irq_status_ctrl: FIFO depths must be at least 1");
   end
   if (RX_CNT_W < $clog2(RX_DEPTH + 1) || TX_CNT_W < $clog2(TX_DEPTH + 1)) begin : g_bad_cntw
      $error("uart_irq_status_ctrl: count width too narrow for depth");
   end
   if (RX_RST_TRIG > RX_DEPTH || TX_RST_TRIG > TX_DEPTH) begin : g_bad_trig
      $error("uart_irq_status_ctrl: reset trigger level exceeds depth");
   end
   if (REG_W < 16 || REG_W < RX_CNT_W || REG_W < TX_CNT_W) begin : g_bad_regw
      $error("uart_irq_status_ctrl: register width too small");
   end
   if (ADDR_W < 3) begin : g_bad_addrw
      $error("uart_irq_status_ctrl: address width below 3");
   end

   localparam logic [ADDR_W-1:0] AD_ENABLE  = ADDR_W'(A_ENABLE);
   localparam logic [ADDR_W-1:0] AD_DISABLE = ADDR_W'(A_DISABLE);
   localparam logic [ADDR_W-1:0] AD_MASK    = ADDR_W'(A_MASK);
   localparam logic [ADDR_W-1:0] AD_STICKY  = ADDR_W'(A_STICKY);
   localparam logic [ADDR_W-1:0] AD_LIVE    = ADDR_W'(A_LIVE);
   localparam logic [ADDR_W-1:0] AD_RXTRIG  = ADDR_W'(A_RXTRIG);
   localparam logic [ADDR_W-1:0] AD_TXTRIG  = ADDR_W'(A_TXTRIG);

   // ------------------------------------------------------------------
   // trigger levels
   // ------------------------------------------------------------------
   logic [RX_CNT_W-1:0] rx_trig;
   logic [TX_CNT_W-1:0] tx_trig;

   uisc_trig_regs #(
      .RX_CNT_W    (RX_CNT_W),
      .TX_CNT_W    (TX_CNT_W),
      .RX_RST_TRIG (RX_RST_TRIG),
      .TX_RST_TRIG (TX_RST_TRIG)
   ) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_we_i    (wr_en && (wr_addr == AD_RXTRIG)),
      .tx_we_i    (wr_en && (wr_addr == AD_TXTRIG)),
      .rx_wdata_i (wr_data[RX_CNT_W-1:0]),
      .tx_wdata_i (wr_data[TX_CNT_W-1:0]),
      .rx_trig_o  (rx_trig),
      .tx_trig_o  (tx_trig)
   );

   // ------------------------------------------------------------------
   // live status word
   // ------------------------------------------------------------------
   logic [REG_W-1:0] live;

   uisc_level_flags #(
      .RX_DEPTH (RX_DEPTH),
      .TX_DEPTH (TX_DEPTH),
      .RX_CNT_W (RX_CNT_W),
      .TX_CNT_W (TX_CNT_W),
      .REG_W    (REG_W)
   ) u_flags (
      .rx_count_i (rx_count),
      .tx_count_i (tx_count),
      .rx_trig_i  (rx_trig),
      .tx_trig_i  (tx_trig),
      .live_o     (live)
   );

   // ------------------------------------------------------------------
   // sticky interrupt status
   // ------------------------------------------------------------------
   evt_s            evt;
   logic [IS_W-1:0] st_set;
   logic [IS_W-1:0] st_clr;
   logic [IS_W-1:0] sticky;

   always_comb begin
      evt.rx_ovr  = ev_rx_overrun;
      evt.frame   = ev_frame_err;
      evt.parity  = ev_parity_err;
      evt.timeout = ev_rx_timeout;
      evt.modem   = ev_modem_chg;
      evt.tx_ovr  = ev_tx_overrun;
   end

   always_comb begin
      st_set             = '0;
      st_set[4:0]        = live[4:0];
      st_set[IS_RX_OVR]  = evt.rx_ovr;
      st_set[IS_FRAME]   = evt.frame;
      st_set[IS_PARITY]  = evt.parity;
      st_set[IS_TIMEOUT] = evt.timeout;
      st_set[IS_MODEM]   = evt.modem;
      st_set[IS_TX_TRIG] = live[LV_TX_TRIG];
      st_set[IS_TX_OVR]  = evt.tx_ovr;
   end

   assign st_clr = (wr_en && (wr_addr == AD_STICKY)) ? wr_data[IS_W-1:0] : '0;

   uisc_bit_bank #(
      .W    (IS_W),
      .IMPL (IS_IMPL)
   ) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set),
      .clr_i (st_clr),
      .q_o   (sticky)
   );

   // ------------------------------------------------------------------
   // interrupt mask: set and clear through separate addresses
   // ------------------------------------------------------------------
   logic [IS_W-1:0] mk_set;
   logic [IS_W-1:0] mk_clr;
   logic [IS_W-1:0] mask;

   assign mk_set = (wr_en && (wr_addr == AD_ENABLE))  ? wr_data[IS_W-1:0] : '0;
   assign mk_clr = (wr_en && (wr_addr == AD_DISABLE)) ? wr_data[IS_W-1:0] : '0;

   uisc_bit_bank #(
      .W    (IS_W),
      .IMPL (IS_IMPL)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (mk_set),
      .clr_i (mk_clr),
      .q_o   (mask)
   );

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data[REG_W-1:IS_W];

   // ------------------------------------------------------------------
   // interrupt output
   // ------------------------------------------------------------------
   uisc_irq_out #(
      .W        (IS_W),
      .SYNC_IRQ (SYNC_IRQ)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_i   (mask),
      .sticky_i (sticky),
      .irq_o    (irq)
   );

   // ------------------------------------------------------------------
   // outputs and read port
   // ------------------------------------------------------------------
   assign live_status = live;
   assign irq_status  = REG_W'(sticky);
   assign irq_mask    = REG_W'(mask);

   always_comb begin
      case (rd_addr)
         AD_MASK:   rd_data = REG_W'(mask);
         AD_STICKY: rd_data = REG_W'(sticky);
         AD_LIVE:   rd_data = live;
         AD_RXTRIG: rd_data = REG_W'(rx_trig);
         AD_TXTRIG: rd_data = REG_W'(tx_trig);
         default:   rd_data = '0;
      endcase
   end

endmodule

// File: rtl/uisc_checker.sv
module uisc_checker
   import uisc_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int ADDR_W   = 4,
   parameter bit SYNC_IRQ = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_rx_overrun,
   input logic              ev_frame_err,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  live_status,
   input logic [REG_W-1:0]  irq_status,
   input logic [REG_W-1:0]  irq_mask,
   input logic              irq
);

   localparam logic [REG_W-1:0] IMPL_W = REG_W'(IS_IMPL);

   AST_RESET_CLEAN: assert property (@(posedge clk)
      !rst_n |=> (irq_status == '0) && (irq_mask == '0)); // R8

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_overrun |=> irq_status[IS_RX_OVR]); // R3

   AST_LEVEL_RXFULL: assert property (@(posedge clk) disable iff (!rst_n)
      live_status[LV_RX_FULL] |=> irq_status[LV_RX_FULL]); // R2

   AST_LEVEL_TXTRIG: assert property (@(posedge clk) disable iff (!rst_n)
      live_status[LV_TX_TRIG] |=> irq_status[IS_TX_TRIG]); // R2

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == ADDR_W'(A_STICKY)))
      |=> (($past(irq_status) & ~irq_status) == '0)); // R4

   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(A_STICKY)) && wr_data[IS_FRAME] && ev_frame_err)
      |=> irq_status[IS_FRAME]); // R5

   AST_MASK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(A_MASK))) |=> $stable(irq_mask)); // R6

   AST_MASK_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_W'(A_ENABLE)))
      |=> ((irq_mask & $past(wr_data & IMPL_W)) == $past(wr_data & IMPL_W))); // R6

   if (SYNC_IRQ) begin : g_sync_chk
      AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(irq_mask & irq_status)))); // R7
   end

endmodule

bind uart_irq_status_ctrl uisc_checker #(
   .REG_W    (REG_W),
   .ADDR_W   (ADDR_W),
   .SYNC_IRQ (SYNC_IRQ)
) u_uisc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_rx_overrun (ev_rx_overrun),
   .ev_frame_err  (ev_frame_err),
   .wr_en         (wr_en),
   .wr_addr       (wr_addr),
   .wr_data       (wr_data),
   .live_status   (live_status),
   .irq_status    (irq_status),
   .irq_mask      (irq_mask),
   .irq           (irq)
);

// File: tb/test_uart_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_status_ctrl;

   localparam int RXD  = 64;
   localparam int TXD  = 64;
   localparam int CW   = 7;
   localparam int RW   = 32;
   localparam int AW   = 4;
   localparam int TCLK = 20;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] rx_count, tx_count;
   logic          ev_rx_overrun, ev_frame_err, ev_parity_err;
   logic          ev_rx_timeout, ev_modem_chg, ev_tx_overrun;
   logic          wr_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [RW-1:0] wr_data;
   logic [RW-1:0] rd_data, live_status, irq_status, irq_mask;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(TCLK/2) clk = ~clk;

   uart_irq_status_ctrl #(
      .RX_DEPTH (RXD), .TX_DEPTH (TXD), .RX_CNT_W (CW), .TX_CNT_W (CW),
      .RX_RST_TRIG (32), .TX_RST_TRIG (32), .REG_W (RW), .ADDR_W (AW), .SYNC_IRQ (1'b1)
   ) i_uart_irq_status_ctrl (
      .clk (clk), .rst_n (rst_n), .rx_count (rx_count), .tx_count (tx_count),
      .ev_rx_overrun (ev_rx_overrun), .ev_frame_err (ev_frame_err),
      .ev_parity_err (ev_parity_err), .ev_rx_timeout (ev_rx_timeout),
      .ev_modem_chg (ev_modem_chg), .ev_tx_overrun (ev_tx_overrun),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .rd_addr (rd_addr),
      .rd_data (rd_data), .live_status (live_status), .irq_status (irq_status),
      .irq_mask (irq_mask), .irq (irq)
   );

   task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [RW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [RW-1:0] exp);
      rd_addr = AW'(a);
      #1;
      chk(req, rd_data, exp);
   endtask

   function automatic int evt_pos(input int k);
      case (k)
         0: return 5;  1: return 6;  2: return 7;
         3: return 8;  4: return 9;  default: return 12;
      endcase
   endfunction

   task automatic set_evt(input int k, input logic v);
      case (k)
         0: ev_rx_overrun = v;  1: ev_frame_err  = v;  2: ev_parity_err = v;
         3: ev_rx_timeout = v;  4: ev_modem_chg  = v;  default: ev_tx_overrun = v;
      endcase
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      set_evt(k, 1'b1);
      @(negedge clk);
      set_evt(k, 1'b0);
   endtask

   function automatic logic [RW-1:0] exp_live(input int rc, input int tc, input int rt, input int tt);
      logic [RW-1:0] v;
      v = '0;
      v[0]  = (rc >= rt);
      v[1]  = (rc == 0);
      v[2]  = (rc == RXD);
      v[3]  = (tc == 0);
      v[4]  = (tc == TXD);
      v[13] = (tc >= tt);
      return v;
   endfunction

   task automatic neutral_clear();
      rx_count = 7'd5; tx_count = 7'd5;
      wr(3, '1);
   endtask

   // watchdog
   initial begin
      #(TCLK * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int trig [5] = '{0, 1, 32, 63, 64};
      rst_n = 1'b0; rx_count = '0; tx_count = '0;
      ev_rx_overrun = 0; ev_frame_err = 0; ev_parity_err = 0;
      ev_rx_timeout = 0; ev_modem_chg = 0; ev_tx_overrun = 0;
      wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) tick();

      // R8 reset state
      chk("R8 mask", irq_mask, '0);
      chk("R8 sticky", irq_status, '0);
      chk("R8 irq", {31'b0, irq}, '0);
      rd_chk("R8 rx trig", 5, 32);
      rd_chk("R8 tx trig", 6, 32);

      rx_count = 7'd5; tx_count = 7'd5;
      tick();
      rst_n = 1'b1;
      tick(); tick();
      chk("R2 neutral sticky", irq_status, '0);

      // R9 trigger registers, width truncation
      wr(5, 32'h1A5);
      rd_chk("R9 rx trig trunc", 5, 32'h25);
      wr(6, 32'hFFFF_FF83);
      rd_chk("R9 tx trig trunc", 6, 32'h03);

      // R1 live sweep over all counts for several trigger levels
      for (int t = 0; t < 5; t++) begin
         wr(5, trig[t]);
         wr(6, trig[t]);
         rd_chk("R9 rx trig", 5, trig[t]);
         rd_chk("R9 tx trig", 6, trig[t]);
         for (int c = 0; c <= RXD; c++) begin
            int tc;
            tc = (c * 7) % (TXD + 1);
            rx_count = CW'(c); tx_count = CW'(tc);
            #1;
            chk("R1 live", live_status, exp_live(c, tc, trig[t], trig[t]));
            rd_chk("R10 live read", 4, exp_live(c, tc, trig[t], trig[t]));
            tick();
         end
      end
      wr(5, 32); wr(6, 32);
      neutral_clear();
      chk("R4 cleared", irq_status, '0);

      // R2 level conditions captured into sticky
      begin
         int rcs [5] = '{0, 64, 5, 5, 40};
         int tcs [5] = '{5, 5, 0, 64, 5};
         logic [RW-1:0] es [5];
         es[0] = 32'h0002; es[1] = 32'h0005; es[2] = 32'h0008;
         es[3] = 32'h0410; es[4] = 32'h0001;
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rx_count = CW'(rcs[i]); tx_count = CW'(tcs[i]);
            tick();
            chk("R2 level capture", irq_status, es[i]);
            rx_count = 7'd5; tx_count = 7'd5;
            tick();
            chk("R4 hold after condition ends", irq_status, es[i]);
            wr(3, '1);
            chk("R4 clear", irq_status, '0);
         end
      end

      // R2/R4 clearing a bit whose condition persists has no lasting effect
      rx_count = 7'd0;
      tick();
      wr(3, 32'h2);
      chk("R2 persisting level", irq_status, 32'h2);
      neutral_clear();

      // R3 events, R4 zero write leaves bits
      for (int k = 0; k < 6; k++) begin
         pulse(k);
         chk("R3 event bit", irq_status, 32'(1) << evt_pos(k));
         wr(3, 32'h0);
         chk("R4 zero write", irq_status, 32'(1) << evt_pos(k));
         wr(3, '1);
         chk("R4 clear", irq_status, '0);
      end

      // R5 set beats clear in the same cycle
      pulse(1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h40; ev_frame_err = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ev_frame_err = 1'b0;
      chk("R5 set wins", irq_status, 32'h40);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h40; ev_parity_err = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ev_parity_err = 1'b0;
      chk("R5 other bit clears", irq_status, 32'h80);
      wr(3, '1);

      // R6 mask set/clear addresses
      wr(0, 32'h00F0);
      chk("R6 enable", irq_mask, 32'h00F0);
      wr(0, 32'h0300);
      chk("R6 enable or", irq_mask, 32'h03F0);
      wr(1, 32'h0030);
      chk("R6 disable", irq_mask, 32'h03C0);
      wr(2, 32'hFFFF);
      chk("R6 direct ignored", irq_mask, 32'h03C0);
      rd_chk("R10 mask read", 2, 32'h03C0);
      wr(0, '1);
      chk("R6 implemented bits", irq_mask, 32'h17FF);
      wr(1, '1);
      chk("R6 disable all", irq_mask, '0);

      // R7 registered interrupt timing
      pulse(2);
      tick();
      chk("R7 masked off", {31'b0, irq}, 0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h80;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 mask now set", irq_mask, 32'h80);
      chk("R7 lag one cycle", {31'b0, irq}, 0);
      tick();
      chk("R7 irq rises", {31'b0, irq}, 1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h80;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R4 sticky cleared", irq_status, '0);
      chk("R7 irq still high", {31'b0, irq}, 1);
      tick();
      chk("R7 irq falls", {31'b0, irq}, 0);

      // R7 mask vs event matrix
      for (int k = 0; k < 6; k++) begin
         for (int m = 0; m < 6; m++) begin
            wr(1, '1);
            wr(3, '1);
            wr(0, 32'(1) << evt_pos(m));
            pulse(k);
            tick();
            chk("R7 matrix", {31'b0, irq}, (k == m) ? 1 : 0);
         end
      end
      wr(1, '1);
      wr(3, '1);

      // R10 unmapped addresses
      rd_chk("R10 addr0", 0, '0);
      rd_chk("R10 addr1", 1, '0);
      rd_chk("R10 addr7", 7, '0);
      rd_chk("R10 addr15", 15, '0);
      pulse(5);
      rd_chk("R10 sticky read", 3, 32'h1000);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule